// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the register transfers a processor core makes when it takes an interrupt that an arbiter has already accepted. The arbiter presents a request level together with a source code. The sequencer waits until the execution pipeline signals an instruction boundary. It then captures the source code in two event registers and copies the status word and program counter into shadow copies. It raises three control flags in the status word and redirects the program counter to the handler address. The handler address is the vector base plus a fixed offset of 0x600, and it takes effect with no delay slot.

A return-from-exception strobe undoes the entry in a single cycle by copying the shadow registers back. The rest of the core updates the status word, program counter and vector base through plain write ports. An entry or a return takes precedence over those writes.

Status word layout: bit 28 is the block flag, bit 29 the register-bank select and bit 30 the privileged-mode flag. Bits 7:4 hold the 4-bit interrupt mask.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `sr` becomes 0x700000F0 (block, bank and privileged flags set, mask 0xF) and `pc`, `vbr`, `ssr`, `spc`, `evt_code`, `evt_code_ext` and `entered` become 0.
- R2: An interrupt is accepted at a clock edge only if all of these hold at that edge: `irq_req` is 1, `insn_boundary` is 1, `sr` bit 28 is 0 and `rte` is 0. Without a boundary strobe nothing is accepted.
- R3: On acceptance, `evt_code` takes `irq_code` and `evt_code_ext` takes `irq_code` zero-extended to 32 bits. Both hold their value at every other edge outside reset.
- R4: On acceptance, `ssr` takes the previous `sr` and `spc` takes the previous `pc`.
- R5: On acceptance, `sr` bits 28, 29 and 30 become 1 and every other bit of `sr` keeps its value, including the mask in bits 7:4.
- R6: After the accepting edge, `pc` equals the pre-edge `vbr` plus 0x600, with no intervening instruction slot.
- R7: While `sr` bit 28 is 1, requests are ignored: `entered`, `pc` and the event registers do not change because of `irq_req`.
- R8: When `rte` is 1 at an edge, `sr` takes `ssr` and `pc` takes `spc` in that one edge, and the shadow registers keep their values.
- R9: If `rte` and an acceptable request coincide, the return happens first. The request is accepted at the next boundary, provided the restored `sr` bit 28 is 0 and the request is still present.
- R10: `sr_wr` and `pc_wr` update `sr` and `pc` only at edges with neither acceptance nor return. `vbr_wr` always updates `vbr`, and an entry in the same cycle vectors through the old `vbr`.
- R11: `entered` is 1 for exactly the one cycle after each accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Accepted-interrupt request level from the arbiter |
| irq_code | input | CODE_W | Source code of the pending interrupt |
| insn_boundary | input | 1 | High in cycles that end an instruction |
| rte | input | 1 | Return-from-exception strobe |
| sr_wr | input | 1 | Status word write enable |
| sr_wdata | input | 32 | Status word write data |
| pc_wr | input | 1 | Program counter write enable |
| pc_wdata | input | 32 | Program counter write data |
| vbr_wr | input | 1 | Vector base write enable |
| vbr_wdata | input | 32 | Vector base write data |
| sr | output | 32 | Status word |
| pc | output | 32 | Program counter |
| ssr | output | 32 | Saved status word |
| spc | output | 32 | Saved program counter |
| vbr | output | 32 | Vector base |
| evt_code | output | CODE_W | First event register |
| evt_code_ext | output | 32 | Second event register, zero-extended code |
| entered | output | 1 | One-cycle pulse after an entry |

## Verification
On every cycle, the assertions check the following: the shadow capture, the flag and mask handling of the status word, the vector address, the one-cycle return, the stability of the event registers between entries, the blocking effect of the block flag, and the single-cycle width of `entered`. Some behaviours can only be shown by the bench scenarios. These are the ordering when a return meets a request, the precedence of entry over the execution write ports, the use of the old vector base when both occur together, and the requirement for a boundary strobe. The bench sweeps every mask value with varied status, PC, vector and code patterns.

// File: rtl/esq_pkg.sv
package esq_pkg;
    localparam int XLEN     = 32;
    localparam int BL_BIT   = 28;
    localparam int RB_BIT   = 29;
    localparam int MD_BIT   = 30;
    localparam int MASK_LSB = 4;
    localparam int MASK_W   = 4;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_ENTER  = 2'd1,
        ACT_RETURN = 2'd2
    } act_e;

    localparam word_t ENTRY_FLAGS = (word_t'(1) << BL_BIT)
                                  | (word_t'(1) << RB_BIT)
                                  | (word_t'(1) << MD_BIT);
    localparam word_t SR_RESET = ENTRY_FLAGS
                               | (word_t'((1 << MASK_W) - 1) << MASK_LSB);

    function automatic word_t sr_on_entry(input word_t s);
        return s | ENTRY_FLAGS;
    endfunction

    function automatic logic sr_blocked(input word_t s);
        return s[BL_BIT];
    endfunction

    function automatic logic [MASK_W-1:0] sr_mask(input word_t s);
        return s[MASK_LSB +: MASK_W];
    endfunction
endpackage

// File: rtl/esq_accept.sv
module esq_accept
    import esq_pkg::*;
(
    input  logic irq_req,
    input  logic insn_boundary,
    input  logic rte,
    input  logic blocked,
    output act_e act
);
    always_comb begin
        if (rte)
            act = ACT_RETURN;
        else if (irq_req && insn_boundary && !blocked)
            act = ACT_ENTER;
        else
            act = ACT_IDLE;
    end
endmodule

// File: rtl/esq_vector.sv
module esq_vector
    import esq_pkg::*;
#(
    parameter word_t VEC_OFS = word_t'(32'h0000_0600)
) (
    input  word_t vbr,
    output word_t handler
);
    always_comb handler = vbr + VEC_OFS;
endmodule

// File: rtl/esq_shadow.sv
module esq_shadow
    import esq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  act_e  act,
    input  word_t sr,
    input  word_t pc,
    output word_t ssr,
    output word_t spc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ssr <= '0;
            spc <= '0;
        end else if (act == ACT_ENTER) begin
            ssr <= sr;
            spc <= pc;
        end
    end

    p_save_r4: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_ENTER) |=> (ssr == $past(sr)) && (spc == $past(pc)));
    p_shadow_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_RETURN) |=> (ssr == $past(ssr)) && (spc == $past(spc)));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import esq_pkg::*;
#(
    parameter int    CODE_W  = 12,
    parameter word_t VEC_OFS = word_t'(32'h0000_0600)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              insn_boundary,
    input  logic              rte,
    input  logic              sr_wr,
    input  logic [XLEN-1:0]   sr_wdata,
    input  logic              pc_wr,
    input  logic [XLEN-1:0]   pc_wdata,
    input  logic              vbr_wr,
    input  logic [XLEN-1:0]   vbr_wdata,
    output logic [XLEN-1:0]   sr,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   spc,
    output logic [XLEN-1:0]   vbr,
    output logic [CODE_W-1:0] evt_code,
    output logic [XLEN-1:0]   evt_code_ext,
    output logic              entered
);
    act_e  act;
    word_t handler;

    esq_accept u_accept (
        .irq_req       (irq_req),
        .insn_boundary (insn_boundary),
        .rte           (rte),
        .blocked       (sr_blocked(sr)),
        .act           (act)
    );

    esq_vector #(.VEC_OFS(VEC_OFS)) u_vector (
        .vbr     (vbr),
        .handler (handler)
    );

    esq_shadow u_shadow (
        .clk (clk),
        .rst (rst),
        .act (act),
        .sr  (sr),
        .pc  (pc),
        .ssr (ssr),
        .spc (spc)
    );

    // Status word and program counter: entry and return outrank execution writes.
    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= SR_RESET;
            pc <= '0;
        end else begin
            unique case (act)
                ACT_ENTER: begin
                    sr <= sr_on_entry(sr);
                    pc <= handler;
                end
                ACT_RETURN: begin
                    sr <= ssr;
                    pc <= spc;
                end
                default: begin
                    if (sr_wr) sr <= sr_wdata;
                    if (pc_wr) pc <= pc_wdata;
                end
            endcase
        end
    end

    // Vector base is written independently of the sequencing.
    always_ff @(posedge clk) begin
        if (rst)         vbr <= '0;
        else if (vbr_wr) vbr <= vbr_wdata;
    end

    // Event registers and entry pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_code     <= '0;
            evt_code_ext <= '0;
            entered      <= 1'b0;
        end else begin
            entered <= (act == ACT_ENTER);
            if (act == ACT_ENTER) begin
                evt_code     <= irq_code;
                evt_code_ext <= word_t'(irq_code);
            end
        end
    end

    p_evt_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !entered |-> (evt_code == $past(evt_code)) && (evt_code_ext == $past(evt_code_ext)));
    p_flags_mask_r5: assert property (@(posedge clk) disable iff (rst)
        entered |-> sr[BL_BIT] && sr[RB_BIT] && sr[MD_BIT]
                    && (sr_mask(sr) == sr_mask($past(sr)))
                    && ((sr & ~ENTRY_FLAGS) == ($past(sr) & ~ENTRY_FLAGS)));
    p_vector_r6: assert property (@(posedge clk) disable iff (rst)
        entered |-> (pc == $past(vbr) + VEC_OFS));
    p_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        (sr_blocked(sr) && !rte) |=> !entered);
    p_return_r8: assert property (@(posedge clk) disable iff (rst)
        rte |=> (sr == $past(ssr)) && (pc == $past(spc)) && !entered);
    p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        entered |=> !entered);
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
    localparam int    CLK_PERIOD = 10;
    localparam int    CW         = 12;
    localparam logic [31:0] FLAGS  = 32'h7000_0000;
    localparam logic [31:0] BLBIT  = 32'h1000_0000;
    localparam logic [31:0] OFS    = 32'h0000_0600;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_req = 1'b0, insn_boundary = 1'b0, rte = 1'b0;
    logic [CW-1:0] irq_code = '0;
    logic sr_wr = 1'b0, pc_wr = 1'b0, vbr_wr = 1'b0;
    logic [31:0] sr_wdata = '0, pc_wdata = '0, vbr_wdata = '0;
    logic [31:0] sr, pc, ssr, spc, vbr, evt_code_ext;
    logic [CW-1:0] evt_code;
    logic entered;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    exc_entry_seq #(.CODE_W(CW)) uut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_code(irq_code),
        .insn_boundary(insn_boundary), .rte(rte),
        .sr_wr(sr_wr), .sr_wdata(sr_wdata), .pc_wr(pc_wr), .pc_wdata(pc_wdata),
        .vbr_wr(vbr_wr), .vbr_wdata(vbr_wdata),
        .sr(sr), .pc(pc), .ssr(ssr), .spc(spc), .vbr(vbr),
        .evt_code(evt_code), .evt_code_ext(evt_code_ext), .entered(entered)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] p, input logic [31:0] v);
        sr_wr = 1; sr_wdata = s; pc_wr = 1; pc_wdata = p; vbr_wr = 1; vbr_wdata = v;
        step();
        sr_wr = 0; pc_wr = 0; vbr_wr = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] s0, p0, v0, v1;
        logic [CW-1:0] c0;
        @(negedge clk);
        repeat (3) step();
        chk("R1 sr", sr, 32'h7000_00F0);
        chk("R1 pc", pc, 0);
        chk("R1 vbr", vbr, 0);
        chk("R1 ssr", ssr, 0);
        chk("R1 spc", spc, 0);
        chk("R1 evt", {20'd0, evt_code}, 0);
        chk("R1 evt_ext", evt_code_ext, 0);
        chk("R1 entered", {31'd0, entered}, 0);
        rst = 0;

        // R7: block flag set from reset, request ignored
        irq_req = 1; insn_boundary = 1; irq_code = 12'h123;
        step();
        irq_req = 0; insn_boundary = 0;
        chk("R7 entered", {31'd0, entered}, 0);
        chk("R7 pc", pc, 0);
        chk("R7 evt", {20'd0, evt_code}, 0);

        for (int m = 0; m < 16; m++) begin
            s0 = ((32'(m) * 32'h0111_0B03) ^ 32'h0C00_0A00);
            s0 = (s0 & ~32'h0000_00F0 & ~BLBIT) | (32'(m) << 4);
            p0 = 32'h0000_1000 + 32'(m) * 4;
            v0 = 32'h8000_0000 + 32'(m) * 32'h100;
            c0 = CW'(12'h400 + m * 37);
            load(s0, p0, v0);

            // R2: request without boundary
            irq_req = 1; irq_code = c0;
            step(); step();
            chk("R2 no boundary entered", {31'd0, entered}, 0);
            chk("R2 no boundary pc", pc, p0);
            // R2: boundary without request
            irq_req = 0; insn_boundary = 1;
            step();
            chk("R2 no request entered", {31'd0, entered}, 0);

            irq_req = 1;
            step();
            irq_req = 0; insn_boundary = 0;
            chk("R11 entered", {31'd0, entered}, 1);
            chk("R5 sr", sr, s0 | FLAGS);
            chk("R4 ssr", ssr, s0);
            chk("R4 spc", spc, p0);
            chk("R6 pc", pc, v0 + OFS);
            chk("R3 evt", {20'd0, evt_code}, {20'd0, c0});
            chk("R3 evt_ext", evt_code_ext, {20'd0, c0});

            // R7: blocked, new request ignored
            irq_req = 1; insn_boundary = 1; irq_code = ~c0;
            step();
            irq_req = 0; insn_boundary = 0;
            chk("R11 pulse ends", {31'd0, entered}, 0);
            chk("R7 pc held", pc, v0 + OFS);
            chk("R7 evt held", {20'd0, evt_code}, {20'd0, c0});

            rte = 1;
            step();
            rte = 0;
            chk("R8 sr", sr, s0);
            chk("R8 pc", pc, p0);
            chk("R8 ssr kept", ssr, s0);
            chk("R3 evt hold", evt_code_ext, {20'd0, c0});
        end

        // R10: plain writes apply when idle
        s0 = 32'h0000_0050; p0 = 32'h0000_2000; v0 = 32'h4000_0000; v1 = 32'h5000_0000;
        load(s0, p0, v0);
        chk("R10 sr write", sr, s0);
        chk("R10 pc write", pc, p0);
        // R10: entry outranks writes; vbr write lands, old vbr used
        irq_req = 1; insn_boundary = 1; irq_code = 12'hABC;
        sr_wr = 1; sr_wdata = 32'h0000_0000; pc_wr = 1; pc_wdata = 32'hDEAD_0000;
        vbr_wr = 1; vbr_wdata = v1;
        step();
        irq_req = 0; insn_boundary = 0; sr_wr = 0; pc_wr = 0; vbr_wr = 0;
        chk("R10 sr entry wins", sr, s0 | FLAGS);
        chk("R10 pc old vbr", pc, v0 + OFS);
        chk("R10 vbr written", vbr, v1);
        chk("R10 ssr", ssr, s0);

        // R9: return meets request
        irq_req = 1; insn_boundary = 1; rte = 1; irq_code = 12'h3C5;
        pc_wr = 1; pc_wdata = 32'h1111_1111;
        step();
        rte = 0; pc_wr = 0;
        chk("R9 return first sr", sr, s0);
        chk("R9 return first pc", pc, p0);
        chk("R9 no entry yet", {31'd0, entered}, 0);
        chk("R9 evt unchanged", {20'd0, evt_code}, 32'hABC);
        step();
        irq_req = 0; insn_boundary = 0;
        chk("R9 entry next boundary", {31'd0, entered}, 1);
        chk("R9 pc vector", pc, v1 + OFS);
        chk("R9 evt", {20'd0, evt_code}, 32'h3C5);
        chk("R9 spc", spc, p0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule